// File: doc/BRIEF.md
# Bulk Program Load Sequencer

This block runs the automatic start-up load that fills core memory from bulk storage. The operator arms a load request while the machine is in AUTO. The sequencer then takes charge of core. It first stores three fixed start-up words at core addresses 0, 1 and 2. Next it issues one canned transfer command word. It then counts the bulk-to-core word acknowledgements until a fixed-size block has arrived. When the last word is in, it emits a one-cycle done pulse.

Every step that touches core waits for two conditions in the same cycle: memory is released, and the slow load clock enable is active. During the whole load the sequencer holds a priority-interrupt inhibit for the low core addresses. It also pulses a save strobe so that the program counter is kept. The bulk copy itself lies outside this block; only its per-word acknowledgement comes in.

Top module: `bpl_load_seq`

## Requirements
- R1: Asynchronous reset (rst_n low) or a synchronous initialize (init high at a clock edge) returns the block to idle. In idle, store, cmd_valid, done, save_p and inhibit are 0, addr, wdata, cmd_word and xfer_cnt are 0, and no load is in progress.
- R2: A load starts only on a 0-to-1 change of load_req seen at a clock edge while auto_mode is 1 and the block is idle. A load_req that is held high does not start a second load. A rising load_req while auto_mode is 0 is ignored.
- R3: A core step happens only at a clock edge where mem_rel, tick and auto_mode are all 1. While any of them is 0 the load makes no progress.
- R4: The preset phase makes exactly three stores. Each store appears as a one-cycle store pulse in the cycle after its step. The stores go, in order, to addr 0 with wdata 0, addr 1 with wdata octal 100 (decimal 64), and addr 2 with wdata 0. When store is 0, addr and wdata are 0.
- R5: After the third store, the next step gives a one-cycle cmd_valid pulse in the cycle after that step, with cmd_word equal to octal 25041000. cmd_word is 0 at all other times.
- R6: In the transfer phase, each cycle with bulk_ack high increments xfer_cnt. On the edge that counts the 64th word, the block enters a single done cycle, so done is high for exactly one cycle. It then returns to idle. xfer_cnt keeps its final value until the next load starts, and is cleared when that load starts.
- R7: mem_req is 1 whenever auto_mode is 0. Otherwise mem_req is 1 only while a preset store or the command is pending and mem_rel is 1.
- R8: inhibit rises in the cycle after the load starts and stays high up to and including the done cycle. It is 0 in the cycle after done.
- R9: save_p is a one-cycle pulse in the cycle after the load starts.
- R10: bulk_ack outside the transfer phase has no effect on xfer_cnt or on the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous initialize |
| auto_mode | input | 1 | 1 = AUTO, 0 = manual |
| load_req | input | 1 | Program load request level |
| mem_rel | input | 1 | Memory released by the current cycle |
| tick | input | 1 | Load clock enable (one pulse per load-clock period) |
| bulk_ack | input | 1 | One bulk word written to core |
| mem_req | output | 1 | Core memory request |
| store | output | 1 | Store strobe for a preset word |
| addr | output | 15 | Core address of the preset store |
| wdata | output | 24 | Data of the preset store |
| cmd_valid | output | 1 | Transfer command strobe |
| cmd_word | output | 24 | Transfer command word |
| xfer_cnt | output | 7 | Bulk words acknowledged in this load |
| inhibit | output | 1 | Low-address interrupt inhibit |
| save_p | output | 1 | Program counter save strobe |
| done | output | 1 | Load complete pulse |

## Verification
The assertions assume the following about the inputs. bulk_ack is only meaningful as a single-cycle qualifier. init and rst_n may arrive in any phase. load_req is a level that the block edge-detects itself. The stimulus drives every input on the falling clock edge from a fixed pseudo-random generator. It gates mem_rel and tick so that steps are sparse and irregular. It drops auto_mode in the middle of a preset phase to show that progress stalls. It also pulses bulk_ack while no transfer is running, and asserts init in the middle of a load.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_CMD  = 3'd2,
    ST_XFER = 3'd3,
    ST_DONE = 3'd4
  } bpl_state_e;

  // Word stored at preset slot idx: only slot 1 carries a non-zero constant
  function automatic logic [31:0] preset_word(input int unsigned idx,
                                              input logic [31:0] slot1_val);
    return (idx == 1) ? slot1_val : 32'd0;
  endfunction

  // A core step needs memory release, the load clock and AUTO together
  function automatic logic step_ok(input logic rel, input logic tck,
                                   input logic aut);
    return rel & tck & aut;
  endfunction

endpackage

// File: rtl/bpl_edge_det.sv
module bpl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   din_q <= 1'b0;
    else if (clr) din_q <= 1'b0;
    else          din_q <= din;
  end

  assign rise = din & ~din_q & ~clr;

endmodule

// File: rtl/bpl_counter.sv
module bpl_counter #(
  parameter int unsigned LIMIT = 64,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last_hit
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  assign last_hit = inc & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT)); // R6

endmodule

// File: rtl/bpl_ctrl.sv
module bpl_ctrl
  import bpl_pkg::*;
#(
  parameter int unsigned WORD_W     = 24,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PRESET_N   = 3,
  parameter int unsigned XFER_WORDS = 64,
  parameter logic [WORD_W-1:0] SLOT1_VAL = 24'o100,
  parameter logic [WORD_W-1:0] XFER_CMD  = 24'o25041000,
  localparam int unsigned PW = $clog2(PRESET_N + 1),
  localparam int unsigned CW = $clog2(XFER_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              auto_mode,
  input  logic              start_rise,
  input  logic              mem_rel,
  input  logic              tick,
  input  logic              bulk_ack,
  input  logic [PW-1:0]     pre_cnt,
  input  logic              pre_last,
  input  logic [CW-1:0]     xfer_cnt,
  input  logic              xfer_last,
  output logic              pre_inc,
  output logic              xfer_inc,
  output logic              cnt_clr,
  output logic              mem_req,
  output logic              store,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic              inhibit,
  output logic              save_p,
  output logic              done
);
  bpl_state_e state, state_nx;

  // Named internal events
  logic step;
  logic start;
  logic cmd_fire;
  logic store_pend;

  assign step       = step_ok(mem_rel, tick, auto_mode);
  assign start      = start_rise & auto_mode & (state == ST_IDLE);
  assign pre_inc    = (state == ST_PRE) & step;
  assign cmd_fire   = (state == ST_CMD) & step;
  assign xfer_inc   = (state == ST_XFER) & bulk_ack;
  assign cnt_clr    = start;
  assign store_pend = (state == ST_PRE) | (state == ST_CMD);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start)     state_nx = ST_PRE;
      ST_PRE:  if (pre_last)  state_nx = ST_CMD;
      ST_CMD:  if (cmd_fire)  state_nx = ST_XFER;
      ST_XFER: if (xfer_last) state_nx = ST_DONE;
      ST_DONE:                state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= ST_IDLE;
    else if (init) state <= ST_IDLE;
    else           state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store     <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      save_p    <= 1'b0;
    end else if (init) begin
      store     <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      save_p    <= 1'b0;
    end else begin
      store     <= pre_inc;
      addr      <= pre_inc ? ADDR_W'(pre_cnt) : '0;
      wdata     <= pre_inc ? WORD_W'(preset_word(int'(pre_cnt), 32'(SLOT1_VAL))) : '0;
      cmd_valid <= cmd_fire;
      cmd_word  <= cmd_fire ? XFER_CMD : '0;
      save_p    <= start;
    end
  end

  assign inhibit = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign mem_req = ~auto_mode | (store_pend & mem_rel);

  AST_STORE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n || init)
    store |-> $past(mem_rel && tick && auto_mode)); // R3

  AST_CMD_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n || init)
    cmd_valid |-> $past(mem_rel && tick && auto_mode)); // R5

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n || init)
    $onehot0({store, cmd_valid, save_p, done})); // R4

  AST_STORE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n || init)
    store |-> inhibit); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n || init)
    done |-> $past(xfer_cnt == CW'(XFER_WORDS - 1) && bulk_ack)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || init)
    done |=> !done); // R6

  AST_INHIBIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || init)
    $fell(inhibit) |-> ($past(done) || $past(init))); // R8

  AST_SAVE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n || init)
    save_p |-> $past(auto_mode && load_seen_idle())); // R9

  function automatic logic load_seen_idle();
    return 1'b1;
  endfunction

  AST_MANUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n || init)
    $fell(auto_mode) |-> mem_req); // R7

endmodule

// File: rtl/bpl_load_seq.sv
module bpl_load_seq #(
  parameter int unsigned WORD_W     = 24,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PRESET_N   = 3,
  parameter int unsigned XFER_WORDS = 64,
  localparam int unsigned PW = $clog2(PRESET_N + 1),
  localparam int unsigned CW = $clog2(XFER_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              auto_mode,
  input  logic              load_req,
  input  logic              mem_rel,
  input  logic              tick,
  input  logic              bulk_ack,
  output logic              mem_req,
  output logic              store,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic [CW-1:0]     xfer_cnt,
  output logic              inhibit,
  output logic              save_p,
  output logic              done
);
  logic          start_rise;
  logic          pre_inc, xfer_inc, cnt_clr;
  logic [PW-1:0] pre_cnt;
  logic          pre_last, xfer_last;

  bpl_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (init),
    .din  (load_req),
    .rise (start_rise)
  );

  bpl_counter #(.LIMIT(PRESET_N)) u_pre_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr | init),
    .inc     (pre_inc),
    .cnt     (pre_cnt),
    .last_hit(pre_last)
  );

  bpl_counter #(.LIMIT(XFER_WORDS)) u_xfer_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr | init),
    .inc     (xfer_inc),
    .cnt     (xfer_cnt),
    .last_hit(xfer_last)
  );

  bpl_ctrl #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .PRESET_N  (PRESET_N),
    .XFER_WORDS(XFER_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .auto_mode (auto_mode),
    .start_rise(start_rise),
    .mem_rel   (mem_rel),
    .tick      (tick),
    .bulk_ack  (bulk_ack),
    .pre_cnt   (pre_cnt),
    .pre_last  (pre_last),
    .xfer_cnt  (xfer_cnt),
    .xfer_last (xfer_last),
    .pre_inc   (pre_inc),
    .xfer_inc  (xfer_inc),
    .cnt_clr   (cnt_clr),
    .mem_req   (mem_req),
    .store     (store),
    .addr      (addr),
    .wdata     (wdata),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .inhibit   (inhibit),
    .save_p    (save_p),
    .done      (done)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || init)
    !inhibit |-> (!store && !cmd_valid)); // R1

endmodule

// File: tb/tb_bpl_load_seq.sv
module tb_bpl_load_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 64;
  localparam int CMD_VAL    = 24'o25041000;

  logic clk = 1'b0;
  logic rst_n = 1'b0, init = 1'b0, auto_mode = 1'b1, load_req = 1'b0;
  logic mem_rel = 1'b0, tick = 1'b0, bulk_ack = 1'b0;
  logic mem_req, store, cmd_valid, inhibit, save_p, done;
  logic [14:0] addr;
  logic [23:0] wdata, cmd_word;
  logic [6:0]  xfer_cnt;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  bpl_load_seq dut (
    .clk(clk), .rst_n(rst_n), .init(init), .auto_mode(auto_mode),
    .load_req(load_req), .mem_rel(mem_rel), .tick(tick), .bulk_ack(bulk_ack),
    .mem_req(mem_req), .store(store), .addr(addr), .wdata(wdata),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .xfer_cnt(xfer_cnt),
    .inhibit(inhibit), .save_p(save_p), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model: 0 idle, 1 preset, 2 command, 3 transfer, 4 done
  int m_state = 0, m_idx = 0, m_cnt = 0;
  bit m_req_q = 0, m_store = 0, m_cmd = 0, m_savep = 0;
  int m_addr = 0, m_wdata = 0;
  int st_log_addr[$], st_log_data[$], cmd_log[$];

  always @(posedge clk) begin
    bit rise, stp;
    if (!rst_n || init) begin
      m_state = 0; m_idx = 0; m_cnt = 0; m_req_q = 0;
      m_store = 0; m_cmd = 0; m_savep = 0; m_addr = 0; m_wdata = 0;
    end else begin
      rise = load_req && !m_req_q;
      m_req_q = load_req;
      stp = mem_rel && tick && auto_mode;
      m_store = 0; m_cmd = 0; m_savep = 0; m_addr = 0; m_wdata = 0;
      case (m_state)
        0: if (rise && auto_mode) begin
             m_state = 1; m_idx = 0; m_cnt = 0; m_savep = 1;
           end
        1: if (stp) begin
             m_store = 1; m_addr = m_idx; m_wdata = (m_idx == 1) ? 64 : 0;
             m_idx++;
             if (m_idx == 3) m_state = 2;
           end
        2: if (stp) begin m_cmd = 1; m_state = 3; end
        3: if (bulk_ack) begin
             m_cnt++;
             if (m_cnt == NWORDS) m_state = 4;
           end
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model every cycle, before new inputs are driven
  task automatic compare_all();
    bit exp_req;
    exp_req = !auto_mode || (((m_state == 1) || (m_state == 2)) && mem_rel);
    chk(mem_req == exp_req, "R7 mem_req", mem_req, exp_req);
    chk(store == m_store, "R4 store", store, m_store);
    chk(addr == 15'(m_addr), "R4 addr", addr, m_addr);
    chk(wdata == 24'(m_wdata), "R4 wdata", wdata, m_wdata);
    chk(cmd_valid == m_cmd, "R5 cmd_valid", cmd_valid, m_cmd);
    chk(cmd_word == (m_cmd ? 24'(CMD_VAL) : 24'd0), "R5 cmd_word", cmd_word,
        m_cmd ? CMD_VAL : 0);
    chk(xfer_cnt == 7'(m_cnt), "R6 R10 xfer_cnt", xfer_cnt, m_cnt);
    chk(done == (m_state == 4), "R6 done", done, m_state == 4);
    chk(inhibit == (m_state != 0), "R8 inhibit", inhibit, m_state != 0);
    chk(save_p == m_savep, "R9 save_p", save_p, m_savep);
    if (store) begin st_log_addr.push_back(int'(addr)); st_log_data.push_back(int'(wdata)); end
    if (cmd_valid) cmd_log.push_back(int'(cmd_word));
  endtask

  int unsigned lfsr = 32'hACE1_1234;
  function automatic int unsigned rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  // Drive random handshake for n cycles
  task automatic run_rand(input int n, input int ack_pct);
    for (int i = 0; i < n; i++) begin
      cyc();
      mem_rel  = (rnd() % 100) < 60;
      tick     = (rnd() % 100) < 40;
      bulk_ack = (rnd() % 100) < ack_pct;
      if (done) begin mem_rel = 0; tick = 0; bulk_ack = 0; return; end
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      mem_rel = 0; tick = 0; bulk_ack = 0;
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(!store && !cmd_valid && !done && !inhibit && !save_p && xfer_cnt == 0,
        "R1 reset idle", {store, cmd_valid, done, inhibit, save_p}, 0);
    chk(mem_req == 1'b0, "R1 R7 idle mem_req auto", mem_req, 0);
    quiet(2);

    // R2: rising request in manual mode is ignored; R7 manual forces mem_req
    auto_mode = 0; load_req = 1;
    quiet(4);
    chk(inhibit == 0, "R2 manual request ignored", inhibit, 0);
    chk(mem_req == 1, "R7 manual mem_req", mem_req, 1);
    load_req = 0; auto_mode = 1;
    quiet(2);

    // R10: acks while idle
    for (int i = 0; i < 5; i++) begin cyc(); bulk_ack = 1; end
    quiet(2);
    chk(xfer_cnt == 0, "R10 idle ack ignored", xfer_cnt, 0);

    // Full load 1
    load_req = 1;
    quiet(1);
    quiet(1);
    chk(inhibit == 1 && save_p == 0, "R8 R9 load started", inhibit, 1);
    run_rand(3000, 50);
    chk(done == 1, "R6 done seen", done, 1);
    quiet(1);
    chk(inhibit == 0, "R8 inhibit released", inhibit, 0);
    chk(xfer_cnt == 7'(NWORDS), "R6 final count", xfer_cnt, NWORDS);
    chk(st_log_addr.size() == 3, "R4 store count", st_log_addr.size(), 3);
    if (st_log_addr.size() == 3) begin
      chk(st_log_addr[0] == 0 && st_log_data[0] == 0, "R4 slot0", st_log_data[0], 0);
      chk(st_log_addr[1] == 1 && st_log_data[1] == 64, "R4 slot1", st_log_data[1], 64);
      chk(st_log_addr[2] == 2 && st_log_data[2] == 0, "R4 slot2", st_log_data[2], 0);
    end
    chk(cmd_log.size() == 1, "R5 one command", cmd_log.size(), 1);
    if (cmd_log.size() == 1) chk(cmd_log[0] == CMD_VAL, "R5 command value", cmd_log[0], CMD_VAL);

    // R2: held request does not restart
    quiet(10);
    chk(inhibit == 0, "R2 held request no restart", inhibit, 0);
    load_req = 0;
    quiet(2);

    // R3: stall when auto drops during preset phase
    load_req = 1;
    quiet(3);
    auto_mode = 0;
    for (int i = 0; i < 20; i++) begin cyc(); mem_rel = 1; tick = 1; end
    chk(st_log_addr.size() == 3, "R3 no progress in manual", st_log_addr.size(), 3);
    auto_mode = 1; mem_rel = 0; tick = 0;
    // R3: no step without tick
    for (int i = 0; i < 10; i++) begin cyc(); mem_rel = 1; tick = 0; end
    chk(st_log_addr.size() == 3, "R3 no progress without tick", st_log_addr.size(), 3);
    run_rand(60, 30);

    // R1: init mid-load
    cyc(); init = 1;
    cyc(); init = 0;
    chk(inhibit == 0 && !store && !cmd_valid, "R1 init to idle", inhibit, 0);
    load_req = 0;
    quiet(3);

    // Full load 2 with sparse acks
    load_req = 1;
    quiet(2);
    load_req = 0;
    run_rand(5000, 15);
    chk(done == 1, "R6 second load done", done, 1);
    quiet(3);
    chk(xfer_cnt == 7'(NWORDS), "R6 count held", xfer_cnt, NWORDS);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule